// File: doc/BRIEF.md
# Serial Phase Word Decoder

This block turns a recovered serial bit stream into decoded parallel words. Each input bit comes with a strobe. An optional word-start flag marks the first bit of a word. The block gathers 20 bits, least significant first, into one word. A phase-select input, sampled together with the first bit, says whether the word carries video or control information.

A video word holds two overhead bits and eighteen symbol bits. The symbols are inverted when the second overhead bit is set, and passed through unchanged otherwise. The result appears on the 18-bit video output, and the data-enable output goes high.

A control word holds one overhead bit, five control values sent three times each, and four values sent once. Each tripled value is recovered by a 2-of-3 vote, so one flipped copy per triplet is corrected. The four single values are copied straight to the output. The result appears on the 9-bit control output, and data-enable goes low.

Overhead bits that break the encoding rules raise a sticky error flag. A clear input resets the flag. All results sit in an output register that holds its value until the next word has been decoded.

Top module: `serial_word_decoder`

## Requirements
- R1: A word is 20 bits, with bit 0 first. Only strobed bits count. A word-start strobe makes the current bit bit 0 of a new word, whatever the counter held before. Without a word-start, the position wraps from 19 back to 0, so back-to-back words need no marker.
- R2: The phase is taken from `phase_video` only on the strobed bit that carries `word_start`. A value of 1 selects video and 0 selects control. Changes to `phase_video` on other bits have no effect.
- R3: In a video word with bit 1 equal to 0, word bits 2..19 go unchanged to `vid_data[0..17]`.
- R4: In a video word with bit 1 equal to 1, `vid_data[k]` is the inverse of word bit k+2.
- R5: In a control word, `ctl_data[k]` for k = 0..4 is the majority value of word bits 1+3k, 2+3k and 3+3k. Any single wrong copy is corrected. Two wrong copies give the wrong value.
- R6: In a control word, word bits 16, 17, 18 and 19 go unchanged to `ctl_data[5]`, `ctl_data[6]`, `ctl_data[7]` and `ctl_data[8]`.
- R7: A decoded video word sets `de_out` to 1, updates `vid_data` and leaves `ctl_data` unchanged. A decoded control word sets `de_out` to 0, updates `ctl_data` and leaves `vid_data` unchanged.
- R8: Consider the rising edge that captures bit 19. The outputs still hold their old values just after that edge. They take the new word's values at the following edge. With no new word, they keep their values.
- R9: `enc_err` becomes 1 and stays 1 when a control word arrives with bit 0 equal to 1, or a video word arrives with bit 0 equal to 0. A one-cycle `err_clear` pulse returns it to 0.
- R10: While `rst` is high at a clock edge, all outputs, the bit position and the latched phase are cleared. Position 0 and control phase are the starting state.
- R11: Cycles with `bit_valid` low change neither the bit position nor the word being assembled, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| word_start | input | 1 | Current strobed bit is bit 0 of a word |
| phase_video | input | 1 | Phase select sampled with word start: 1 video, 0 control |
| err_clear | input | 1 | Clears the sticky encoding error flag |
| vid_data | output | 18 | Decoded video symbols |
| ctl_data | output | 9 | Decoded control values |
| de_out | output | 1 | High after a video word, low after a control word |
| enc_err | output | 1 | Sticky overhead-bit error flag |

## Verification
Two video words are used: one with the symbols passed through and one with them inverted. Each symbol pattern is asymmetric, so a reversed or shifted bit order shows up.

Three control words are used:
- a clean word, which checks the triplet and direct-bit positions;
- a word with exactly one wrong copy in every triplet, which separates majority voting from taking a single copy;
- a word with two wrong copies in one triplet, which confirms the vote really is 2-of-3.

Words are also sent in several other ways:
- with gaps between strobes and junk on the data line;
- after misaligned junk bits, with a realigning word start;
- back to back with no marker;
- after a reset in the middle of a word.

While any word is being sent, the phase select is driven to the opposite value on every bit except the first. This shows that the phase is sampled only at the word boundary.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int WORD_W   = 20;
    localparam int VID_W    = 18;
    localparam int CTL_W    = 9;
    localparam int N_VOTED  = 5;
    localparam int REP      = 3;
    localparam int N_DIRECT = CTL_W - N_VOTED;
    localparam int CNT_W    = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        PH_CTRL  = 1'b0,
        PH_VIDEO = 1'b1
    } phase_e;

    // one assembled word together with the phase it was framed with
    typedef struct packed {
        phase_e phase;
        word_t  bits;
    } frame_t;

    // decoded content of one word
    typedef struct packed {
        logic [VID_W-1:0] vid;
        logic [CTL_W-1:0] ctl;
        logic             is_video;
        logic             enc_err;
    } dec_t;

    // 2-of-3 vote
    function automatic logic maj3(input logic [2:0] t);
        return (t[0] & t[1]) | (t[0] & t[2]) | (t[1] & t[2]);
    endfunction

endpackage

// File: rtl/swd_bit_assembler.sv
module swd_bit_assembler
    import swd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_valid,
    input  logic   bit_in,
    input  logic   word_start,
    input  logic   phase_video,
    output frame_t frame_q,
    output logic   frame_vld_q
);

    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic [W-1:0]  sh_q;
    logic [W-1:0]  full;
    phase_e        ph_q;
    phase_e        cur_ph;
    logic          last;

    always_comb begin
        idx    = word_start ? '0 : cnt_q;
        last   = (idx == LAST_IDX);
        cur_ph = word_start ? phase_e'(phase_video) : ph_q;
        full   = sh_q;
        full[W-1] = bit_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            sh_q        <= '0;
            ph_q        <= PH_CTRL;
            frame_q     <= '0;
            frame_vld_q <= 1'b0;
        end else begin
            frame_vld_q <= 1'b0;
            if (bit_valid) begin
                sh_q[idx] <= bit_in;
                cnt_q     <= last ? '0 : idx + CW'(1);
                if (word_start) ph_q <= phase_e'(phase_video);
                if (last) begin
                    frame_q.bits  <= full;
                    frame_q.phase <= cur_ph;
                    frame_vld_q   <= 1'b1;
                end
            end
        end
    end

    // R1: position never leaves the word
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX);

    // R11: idle cycles neither advance nor complete a word
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(cnt_q) && !frame_vld_q);

endmodule

// File: rtl/swd_word_decoder.sv
module swd_word_decoder
    import swd_pkg::*;
#(
    parameter int VW = VID_W,
    parameter int NV = N_VOTED,
    parameter int ND = N_DIRECT,
    parameter int RP = REP
) (
    input  frame_t frame,
    output dec_t   dec
);

    localparam int SYM_LSB = 2;
    localparam int TRI_LSB = 1;
    localparam int DIR_LSB = TRI_LSB + RP * NV;

    logic [VW-1:0]    sym;
    logic [NV+ND-1:0] ctl;
    logic             flip;

    assign flip = frame.bits[1];

    // video symbols, optionally inverted as a group
    for (genvar k = 0; k < VW; k++) begin : g_sym
        assign sym[k] = frame.bits[SYM_LSB + k] ^ flip;
    end

    // triplicated control values
    for (genvar k = 0; k < NV; k++) begin : g_vote
        assign ctl[k] = maj3(frame.bits[TRI_LSB + RP*k +: 3]);
    end

    // single-copy control values
    for (genvar j = 0; j < ND; j++) begin : g_direct
        assign ctl[NV + j] = frame.bits[DIR_LSB + j];
    end

    always_comb begin
        dec.vid      = sym;
        dec.ctl      = ctl;
        dec.is_video = (frame.phase == PH_VIDEO);
        dec.enc_err  = (frame.phase == PH_VIDEO) ? ~frame.bits[0] : frame.bits[0];
    end

endmodule

// File: rtl/swd_out_reg.sv
module swd_out_reg
    import swd_pkg::*;
#(
    parameter int VW = VID_W,
    parameter int CW = CTL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  dec_t          dec,
    input  logic          err_clear,
    output logic [VW-1:0] vid_q,
    output logic [CW-1:0] ctl_q,
    output logic          de_q,
    output logic          err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_q <= '0;
            ctl_q <= '0;
            de_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (load) begin
                de_q <= dec.is_video;
                if (dec.is_video) vid_q <= dec.vid;
                else              ctl_q <= dec.ctl;
            end
            err_q <= (err_q & ~err_clear) | (load & dec.enc_err);
        end
    end

    // R8: without a decoded word the outputs hold
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(vid_q) && $stable(ctl_q) && $stable(de_q));

    // R9: flag stays set until cleared
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_q && !err_clear |=> err_q);

    // R10: reset leaves a clean output state
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (vid_q == '0) && (ctl_q == '0) && !de_q && !err_q);

endmodule

// File: rtl/serial_word_decoder.sv
module serial_word_decoder
    import swd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             word_start,
    input  logic             phase_video,
    input  logic             err_clear,
    output logic [VID_W-1:0] vid_data,
    output logic [CTL_W-1:0] ctl_data,
    output logic             de_out,
    output logic             enc_err
);

    frame_t frame;
    logic   frame_vld;
    dec_t   dec;

    swd_bit_assembler u_asm (
        .clk         (clk),
        .rst         (rst),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .word_start  (word_start),
        .phase_video (phase_video),
        .frame_q     (frame),
        .frame_vld_q (frame_vld)
    );

    swd_word_decoder u_dec (
        .frame (frame),
        .dec   (dec)
    );

    swd_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_vld),
        .dec       (dec),
        .err_clear (err_clear),
        .vid_q     (vid_data),
        .ctl_q     (ctl_data),
        .de_q      (de_out),
        .err_q     (enc_err)
    );

    // R7: data-enable rises only after a completed video word
    p_de_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(de_out) |-> $past(frame_vld && frame.phase == PH_VIDEO));

    // R7: data-enable falls only after a completed control word
    p_de_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(de_out) |-> $past(frame_vld && frame.phase == PH_CTRL));

endmodule

// File: tb/serial_word_decoder_tb_top.sv
module serial_word_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        word_start = 1'b0;
    logic        phase_video = 1'b0;
    logic        err_clear = 1'b0;
    logic [17:0] vid_data;
    logic [8:0]  ctl_data;
    logic        de_out;
    logic        enc_err;

    int checks = 0;
    int errors = 0;

    logic [17:0] exp_vid = '0;
    logic [8:0]  exp_ctl = '0;
    logic        exp_de  = 1'b0;
    logic        exp_err = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_word_decoder dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .word_start  (word_start),
        .phase_video (phase_video),
        .err_clear   (err_clear),
        .vid_data    (vid_data),
        .ctl_data    (ctl_data),
        .de_out      (de_out),
        .enc_err     (enc_err)
    );

    // {phase, word[19:0], expected value[17:0]} ; value is vid or ctl
    localparam int NVEC = 6;
    localparam logic [38:0] TBL [NVEC] = '{
        {1'b1, 20'hA970D, 18'h2A5C3},   // R3 symbols passed through
        {1'b1, 20'h3C3C3, 18'h30F0F},   // R4 symbols inverted
        {1'b0, 20'h5E38E, 18'h000B5},   // R5 R6 clean control word
        {1'b0, 20'h5A5AC, 18'h000B5},   // R5 one wrong copy per triplet
        {1'b0, 20'h5E382, 18'h000B4},   // R5 two wrong copies in triplet 0
        {1'b0, 20'hFFFFE, 18'h001FF}    // R6 all values set
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " vid"}, 32'(vid_data), 32'(exp_vid));
        chk({tag, " ctl"}, 32'(ctl_data), 32'(exp_ctl));
        chk({tag, " de"},  32'(de_out),   32'(exp_de));
        chk({tag, " err"}, 32'(enc_err),  32'(exp_err));
    endtask

    // send one word; phase driven inverted on all but the first bit (R2)
    task automatic apply(input logic [19:0] w, input logic ph, input logic st,
                         input int gap, input logic [17:0] expv,
                         input logic errset, input string tag);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_valid   = 1'b1;
            bit_in      = w[i];
            word_start  = st && (i == 0);
            phase_video = (i == 0) ? ph : ~ph;
            if (gap > 0 && i < 19) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    bit_valid   = 1'b0;
                    word_start  = 1'b0;
                    bit_in      = ~bit_in;
                    phase_video = ~phase_video;
                end
            end
        end
        @(negedge clk);              // just after the edge capturing bit 19
        bit_valid  = 1'b0;
        word_start = 1'b0;
        chk("R8 hold before update", {vid_data, ctl_data, de_out},
            {exp_vid, exp_ctl, exp_de});
        @(negedge clk);              // one edge later: new results
        exp_de = ph;
        if (ph) exp_vid = expv;
        else    exp_ctl = expv[8:0];
        exp_err = exp_err | errset;
        chk_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R10 reset state");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i][37:18], TBL[i][38], 1'b1, 0, TBL[i][17:0], 1'b0,
                  TBL[i][38] ? "R2 R3 R4 R7 video" : "R2 R5 R6 R7 control");
        end

        // R11: gaps with junk on the data line
        apply(20'h55555, 1'b1, 1'b1, 2, 18'h15555, 1'b0, "R11 gapped video");

        // R1: misaligned junk, then a realigning word start
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in    = i[0];
        end
        apply(20'h5E38E, 1'b0, 1'b1, 0, 18'h000B5, 1'b0, "R1 realigned control");
        // R1: back-to-back word with no marker, phase stays control
        apply(20'hFFFFE, 1'b0, 1'b0, 0, 18'h001FF, 1'b0, "R1 unmarked control");

        // R8: idle cycles keep outputs
        repeat (5) @(negedge clk);
        chk_all("R8 idle hold");

        // R9: video word with bit 0 low sets the flag
        apply(20'hFFFFC, 1'b1, 1'b1, 0, 18'h3FFFF, 1'b1, "R9 bad video overhead");
        apply(20'h5E38E, 1'b0, 1'b1, 0, 18'h000B5, 1'b0, "R9 sticky after good word");
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        exp_err   = 1'b0;
        chk("R9 cleared", 32'(enc_err), 32'(0));
        apply(20'h5E38F, 1'b0, 1'b1, 0, 18'h000B5, 1'b1, "R9 bad control overhead");

        // R10: reset in the middle of a video word
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            bit_valid   = 1'b1;
            bit_in      = 1'b1;
            word_start  = (i == 0);
            phase_video = 1'b1;
        end
        @(negedge clk);
        bit_valid  = 1'b0;
        word_start = 1'b0;
        rst        = 1'b1;
        repeat (2) @(negedge clk);
        exp_vid = '0; exp_ctl = '0; exp_de = 1'b0; exp_err = 1'b0;
        chk_all("R10 mid-word reset");
        rst = 1'b0;
        // position 0 and control phase after reset, no word start given
        apply(20'hFFFFE, 1'b0, 1'b0, 0, 18'h001FF, 1'b0, "R10 restart from position 0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule